// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers up to 32 level-sensitive interrupt request lines and sorts each one onto one of two processor outputs. A request selected as fast drives the fast-interrupt output. A request selected as normal drives the normal-interrupt output. For normal requests the block also resolves priority and supplies the handler address that the processor should jump to. Software can also raise any request line on its own and release it later.

Priority for normal requests comes from sixteen ordered vector slots. Each slot names a source and holds a handler address. A slot with a lower index wins over one with a higher index. An enabled normal request that no enabled slot names is non-vectored: it gets the shared default address and ranks below every vectored slot. Disabling a slot never masks its source; the source simply drops to the non-vectored class.

Reading the current-address register marks the start of service and freezes the reported address against requests of equal or lower priority. Any write to that register ends service, and arbitration resumes on the following cycle. All registers sit on a simple synchronous word-addressed bus: reads are combinational and writes take effect at the clock edge.

Top module: `irqv_top`

## Requirements
- R1: Bit n of the select, enable, force and both status registers refers to request input n. Word addresses: 0x00 normal status (read), 0x01 fast status (read), 0x02 select, 0x03 enable, 0x04 enable clear, 0x05 force, 0x06 force clear, 0x08 current address, 0x09 default address, 0x40+k slot k address, 0x80+k slot k control. Unmapped reads return 0.
- R2: The select register is read/write and resets to 0. A 1 routes the source to the fast class and a 0 routes it to the normal class.
- R3: Writing the enable register sets the bits written as 1 and leaves the others unchanged. A read returns the enable mask, which resets to 0.
- R4: Writing the enable-clear address clears the enable bits written as 1 and leaves the others unchanged.
- R5: Writing the force address raises the sources written as 1. Writing the force-clear address releases them. A read of the force address returns the force mask. A source counts as active when its input is high or it is forced.
- R6: Normal status is active & enabled & not selected. Fast status is active & enabled & selected. The outputs `irqOut` and `fiqOut` go high one clock after any bit of normal or fast status, respectively, is set.
- R7: A slot control word holds the source number in bits 4:0 and the slot enable in bit 5. Bits 31:6 read as 0. Slot address words are 32-bit read/write.
- R8: The current address is taken from the lowest-index enabled slot whose source has normal status set. If no slot qualifies, the default address is used when some unclaimed source has normal status set, and 0 is used otherwise. A source named only by a disabled slot takes the default address. Fast sources never contribute.
- R9: The current address is updated on the clock after a status change. A read of the current address latches the level being served. Until service ends, only a strictly higher-priority request changes the reported address.
- R10: Any write to the current-address register ends service. The reported address re-arbitrates at the next clock edge after the write.
- R11: After reset all registers hold 0, the current address reads 0 and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| irqReq | input | 32 | Level-sensitive request lines, active high |
| regAddr | input | 8 | Register word address |
| regWrEn | input | 1 | Write strobe |
| regRdEn | input | 1 | Read strobe; a read of the current address starts service |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, valid in the cycle of the read strobe |
| fiqOut | output | 1 | Fast interrupt to the processor, registered |
| irqOut | output | 1 | Normal interrupt to the processor, registered |

## Verification
A corrupted mask register shows up within one clock, either as a wrong status bit or as a wrong level on an output pin. A corrupted slot decode or a wrong priority order returns the wrong handler address on the first current-address read made after the request pattern settles. A service latch that is stuck, or that releases too early, shows up in the sequence of reads taken across the end-of-service write. The bench therefore checks the reported address on the exact cycle after that write as well as one cycle later.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int REG_ADDR_W  = 8;
  localparam int SLOT_IDX_W  = 6;
  localparam int SRC_FIELD_W = 5;

  localparam logic [REG_ADDR_W-1:0] ADR_NSTAT   = 8'h00;
  localparam logic [REG_ADDR_W-1:0] ADR_FSTAT   = 8'h01;
  localparam logic [REG_ADDR_W-1:0] ADR_SELECT  = 8'h02;
  localparam logic [REG_ADDR_W-1:0] ADR_ENSET   = 8'h03;
  localparam logic [REG_ADDR_W-1:0] ADR_ENCLR   = 8'h04;
  localparam logic [REG_ADDR_W-1:0] ADR_FORCE   = 8'h05;
  localparam logic [REG_ADDR_W-1:0] ADR_FORCECL = 8'h06;
  localparam logic [REG_ADDR_W-1:0] ADR_CUR     = 8'h08;
  localparam logic [REG_ADDR_W-1:0] ADR_DEFAULT = 8'h09;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_NSTAT, SEL_FSTAT, SEL_SELECT, SEL_ENABLE,
    SEL_FORCE, SEL_CUR, SEL_DEFAULT, SEL_SLOTADDR, SEL_SLOTCTRL
  } rdSel_e;

  typedef struct packed {
    logic wrSelect;
    logic wrEnSet;
    logic wrEnClr;
    logic wrForceSet;
    logic wrForceClr;
    logic wrDefault;
    logic wrEoi;
    logic rdCur;
    logic wrSlotAddr;
    logic wrSlotCtrl;
    rdSel_e rdSel;
    logic [SLOT_IDX_W-1:0] slotIdx;
  } regStrobe_t;
endpackage

// File: rtl/irqv_ctrl.sv
module irqv_ctrl
  import irqv_pkg::*;
#(
  parameter int NUM_SLOT = 16
) (
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic                  regWrEn,
  input  logic                  regRdEn,
  output regStrobe_t            strb
);
  localparam logic [SLOT_IDX_W:0] SLOT_LIM = (SLOT_IDX_W+1)'(NUM_SLOT);

  logic slotOk;
  assign slotOk = {1'b0, regAddr[SLOT_IDX_W-1:0]} < SLOT_LIM;

  always_comb begin
    strb         = '0;
    strb.rdSel   = SEL_NONE;
    strb.slotIdx = regAddr[SLOT_IDX_W-1:0];
    unique case (regAddr[REG_ADDR_W-1:SLOT_IDX_W])
      2'b01: if (slotOk) begin
        strb.wrSlotAddr = regWrEn;
        if (regRdEn) strb.rdSel = SEL_SLOTADDR;
      end
      2'b10: if (slotOk) begin
        strb.wrSlotCtrl = regWrEn;
        if (regRdEn) strb.rdSel = SEL_SLOTCTRL;
      end
      2'b00: begin
        case (regAddr)
          ADR_NSTAT:   if (regRdEn) strb.rdSel = SEL_NSTAT;
          ADR_FSTAT:   if (regRdEn) strb.rdSel = SEL_FSTAT;
          ADR_SELECT: begin
            strb.wrSelect = regWrEn;
            if (regRdEn) strb.rdSel = SEL_SELECT;
          end
          ADR_ENSET: begin
            strb.wrEnSet = regWrEn;
            if (regRdEn) strb.rdSel = SEL_ENABLE;
          end
          ADR_ENCLR:   strb.wrEnClr = regWrEn;
          ADR_FORCE: begin
            strb.wrForceSet = regWrEn;
            if (regRdEn) strb.rdSel = SEL_FORCE;
          end
          ADR_FORCECL: strb.wrForceClr = regWrEn;
          ADR_CUR: begin
            strb.wrEoi = regWrEn;
            strb.rdCur = regRdEn;
            if (regRdEn) strb.rdSel = SEL_CUR;
          end
          ADR_DEFAULT: begin
            strb.wrDefault = regWrEn;
            if (regRdEn) strb.rdSel = SEL_DEFAULT;
          end
          default: ;
        endcase
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/irqv_datapath.sv
module irqv_datapath
  import irqv_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_SLOT = 16,
  parameter int DATA_W   = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqReq,
  input  regStrobe_t         strb,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  output logic               fiqOut,
  output logic               irqOut
);
  localparam int LVL_W    = $clog2(NUM_SLOT + 2);
  localparam int SPAN     = 1 << SRC_FIELD_W;
  localparam logic [LVL_W-1:0] DEF_LVL  = LVL_W'(NUM_SLOT);
  localparam logic [LVL_W-1:0] IDLE_LVL = LVL_W'(NUM_SLOT + 1);

  logic [NUM_SRC-1:0] selQ, enQ, forceQ, active, nStat, fStat;
  logic [NUM_SRC-1:0] wrMask;
  logic [DATA_W-1:0]  defAddrQ;
  logic [SRC_FIELD_W-1:0] slotSrcQ [NUM_SLOT];
  logic                   slotEnQ  [NUM_SLOT];
  logic [DATA_W-1:0]      slotAddrQ[NUM_SLOT];

  assign wrMask = wrData[NUM_SRC-1:0];
  assign active = irqReq | forceQ;
  assign nStat  = active & enQ & ~selQ;
  assign fStat  = active & enQ & selQ;

  // mask registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ     <= '0;
      enQ      <= '0;
      forceQ   <= '0;
      defAddrQ <= '0;
    end else begin
      if (strb.wrSelect)        selQ   <= wrMask;
      if (strb.wrEnSet)         enQ    <= enQ | wrMask;
      else if (strb.wrEnClr)    enQ    <= enQ & ~wrMask;
      if (strb.wrForceSet)      forceQ <= forceQ | wrMask;
      else if (strb.wrForceClr) forceQ <= forceQ & ~wrMask;
      if (strb.wrDefault)       defAddrQ <= wrData;
    end
  end

  // vector slot storage
  for (genvar g = 0; g < NUM_SLOT; g++) begin : gSlot
    logic hitIdx;
    assign hitIdx = (strb.slotIdx == SLOT_IDX_W'(g));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotSrcQ[g]  <= '0;
        slotEnQ[g]   <= 1'b0;
        slotAddrQ[g] <= '0;
      end else begin
        if (strb.wrSlotCtrl && hitIdx) begin
          slotSrcQ[g] <= wrData[SRC_FIELD_W-1:0];
          slotEnQ[g]  <= wrData[SRC_FIELD_W];
        end
        if (strb.wrSlotAddr && hitIdx) slotAddrQ[g] <= wrData;
      end
    end
  end

  // claim map and vectored hits
  logic [SPAN-1:0]     nWide, claimed;
  logic [NUM_SLOT-1:0] vecHit;
  logic                unclaimedHit;

  assign nWide = SPAN'(nStat);

  always_comb begin
    claimed = '0;
    vecHit  = '0;
    for (int k = 0; k < NUM_SLOT; k++) begin
      if (slotEnQ[k]) begin
        claimed[slotSrcQ[k]] = 1'b1;
        vecHit[k]            = nWide[slotSrcQ[k]];
      end
    end
  end

  assign unclaimedHit = |(nWide & ~claimed);

  // priority resolution: lowest slot index wins, default below all slots
  logic [LVL_W-1:0]  winLevel;
  logic [DATA_W-1:0] winAddr;

  always_comb begin
    winLevel = IDLE_LVL;
    winAddr  = '0;
    if (unclaimedHit) begin
      winLevel = DEF_LVL;
      winAddr  = defAddrQ;
    end
    for (int k = NUM_SLOT - 1; k >= 0; k--) begin
      if (vecHit[k]) begin
        winLevel = LVL_W'(k);
        winAddr  = slotAddrQ[k];
      end
    end
  end

  // current address with service latch
  logic [DATA_W-1:0] curAddrQ;
  logic [LVL_W-1:0]  curLevelQ, servedLevelQ;
  logic              inSvcQ;
  logic              mayUpdate;

  assign mayUpdate = !inSvcQ || (winLevel < servedLevelQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddrQ     <= '0;
      curLevelQ    <= IDLE_LVL;
      servedLevelQ <= IDLE_LVL;
      inSvcQ       <= 1'b0;
    end else begin
      if (strb.wrEoi) begin
        inSvcQ <= 1'b0;
      end else if (strb.rdCur) begin
        inSvcQ       <= 1'b1;
        servedLevelQ <= curLevelQ;
      end
      if (mayUpdate) begin
        curAddrQ  <= winAddr;
        curLevelQ <= winLevel;
      end
    end
  end

  // outputs to the processor
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fiqOut <= 1'b0;
      irqOut <= 1'b0;
    end else begin
      fiqOut <= |fStat;
      irqOut <= |nStat;
    end
  end

  // read mux
  logic [DATA_W-1:0] slotAddrRd, slotCtrlRd;

  always_comb begin
    slotAddrRd = '0;
    slotCtrlRd = '0;
    for (int k = 0; k < NUM_SLOT; k++) begin
      if (strb.slotIdx == SLOT_IDX_W'(k)) begin
        slotAddrRd = slotAddrQ[k];
        slotCtrlRd = DATA_W'({slotEnQ[k], slotSrcQ[k]});
      end
    end
  end

  always_comb begin
    unique case (strb.rdSel)
      SEL_NSTAT:    rdData = DATA_W'(nStat);
      SEL_FSTAT:    rdData = DATA_W'(fStat);
      SEL_SELECT:   rdData = DATA_W'(selQ);
      SEL_ENABLE:   rdData = DATA_W'(enQ);
      SEL_FORCE:    rdData = DATA_W'(forceQ);
      SEL_CUR:      rdData = curAddrQ;
      SEL_DEFAULT:  rdData = defAddrQ;
      SEL_SLOTADDR: rdData = slotAddrRd;
      SEL_SLOTCTRL: rdData = slotCtrlRd;
      default:      rdData = '0;
    endcase
  end

  // assertions
  a_r3_set_keeps_bits: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.wrEnSet) |-> ((enQ & $past(wrMask)) == $past(wrMask)));

  a_r4_clear_drops_bits: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.wrEnClr) |-> ((enQ & $past(wrMask)) == '0));

  a_r5_release_drops_force: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.wrForceClr) |-> ((forceQ & $past(wrMask)) == '0));

  a_r9_hold_in_service: assert property (@(posedge clk) disable iff (!rstN)
    (inSvcQ && !(winLevel < servedLevelQ)) |=> $stable(curAddrQ));

  a_r10_eoi_ends_service: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEoi |=> !inSvcQ);

  a_r8_level_in_range: assert property (@(posedge clk) disable iff (!rstN)
    (curLevelQ <= IDLE_LVL) && (servedLevelQ <= IDLE_LVL));
endmodule

// File: rtl/irqv_top.sv
module irqv_top
  import irqv_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_SLOT = 16,
  parameter int DATA_W   = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_SRC-1:0]    irqReq,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic                  regWrEn,
  input  logic                  regRdEn,
  input  logic [DATA_W-1:0]     regWrData,
  output logic [DATA_W-1:0]     regRdData,
  output logic                  fiqOut,
  output logic                  irqOut
);
  regStrobe_t strb;

  irqv_ctrl #(.NUM_SLOT(NUM_SLOT)) u_ctrl (
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .strb    (strb)
  );

  irqv_datapath #(
    .NUM_SRC (NUM_SRC),
    .NUM_SLOT(NUM_SLOT),
    .DATA_W  (DATA_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .irqReq (irqReq),
    .strb   (strb),
    .wrData (regWrData),
    .rdData (regRdData),
    .fiqOut (fiqOut),
    .irqOut (irqOut)
  );
endmodule

// File: tb/irqv_top_bench.sv
`timescale 1ns/1ps
module irqv_top_bench;
  localparam logic [7:0] A_NST = 8'h00, A_FST = 8'h01, A_SEL = 8'h02,
                         A_ENS = 8'h03, A_ENC = 8'h04, A_FRC = 8'h05,
                         A_FCL = 8'h06, A_CUR = 8'h08, A_DEF = 8'h09;

  logic        clk = 1'b0;
  logic        rstN;
  logic [31:0] irqReq;
  logic [7:0]  regAddr;
  logic        regWrEn, regRdEn;
  logic [31:0] regWrData, regRdData;
  logic        fiqOut, irqOut;

  always #2 clk = ~clk;

  irqv_top u_irqv_top (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .regAddr(regAddr),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regWrData(regWrData),
    .regRdData(regRdData), .fiqOut(fiqOut), .irqOut(irqOut)
  );

  int nTests = 0;
  int nFail  = 0;
  bit done   = 0;

  logic [31:0] mSel, mEn, mForce, mDef;
  logic [4:0]  mSrc  [16];
  logic        mSlEn [16];
  logic [31:0] mAddr [16];

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expN();
    return (irqReq | mForce) & mEn & ~mSel;
  endfunction

  function automatic logic [31:0] expF();
    return (irqReq | mForce) & mEn & mSel;
  endfunction

  function automatic logic [31:0] expCur();
    logic [31:0] n = expN();
    logic [31:0] cl = '0;
    for (int k = 0; k < 16; k++) if (mSlEn[k]) cl[mSrc[k]] = 1'b1;
    for (int k = 0; k < 16; k++) if (mSlEn[k] && n[mSrc[k]]) return mAddr[k];
    if ((n & ~cl) != 0) return mDef;
    return 32'h0;
  endfunction

  task automatic modelReset();
    mSel = '0; mEn = '0; mForce = '0; mDef = '0;
    for (int k = 0; k < 16; k++) begin
      mSrc[k] = '0; mSlEn[k] = 1'b0; mAddr[k] = '0;
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; regWrEn = 0; regRdEn = 0; irqReq = '0;
    regAddr = '0; regWrData = '0;
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic regWrite(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1; regRdEn = 1'b0;
    @(negedge clk);
    regWrEn = 1'b0;
    case (a)
      A_SEL: mSel = d;
      A_ENS: mEn = mEn | d;
      A_ENC: mEn = mEn & ~d;
      A_FRC: mForce = mForce | d;
      A_FCL: mForce = mForce & ~d;
      A_DEF: mDef = d;
      default: begin
        if (a[7:6] == 2'b01 && a[5:4] == 2'b00) mAddr[a[3:0]] = d;
        if (a[7:6] == 2'b10 && a[5:4] == 2'b00) begin
          mSrc[a[3:0]] = d[4:0]; mSlEn[a[3:0]] = d[5];
        end
      end
    endcase
  endtask

  task automatic regRead(logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    regAddr = a; regRdEn = 1'b1; regWrEn = 1'b0;
    #1 v = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic setReq(logic [31:0] r);
    @(negedge clk);
    irqReq = r;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      nTests++; nFail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h1c0de5));
    rstN = 1'b0; irqReq = '0; regAddr = '0; regWrEn = 0; regRdEn = 0; regWrData = '0;
    doReset();

    // R11 reset state
    @(negedge clk);
    check("R11 irqOut", {31'b0, irqOut}, 32'h0);
    check("R11 fiqOut", {31'b0, fiqOut}, 32'h0);
    regRead(A_ENS, v); check("R11 R3 enable reset", v, 32'h0);
    regRead(A_SEL, v); check("R11 R2 select reset", v, 32'h0);
    regRead(A_CUR, v); check("R11 cur reset", v, 32'h0);
    regWrite(A_CUR, 32'h0);

    // R3 / R4 set-only and clear-only
    regWrite(A_ENS, 32'h0000_00F0);
    regWrite(A_ENS, 32'h0000_0300);
    regRead(A_ENS, v); check("R3 set is sticky", v, 32'h0000_03F0);
    regWrite(A_ENC, 32'h0000_0110);
    regRead(A_ENS, v); check("R4 clear drops only ones", v, 32'h0000_02E0);

    // R7 control word layout
    regWrite(8'h83, 32'hFFFF_FFFF);
    regRead(8'h83, v); check("R7 reserved bits zero", v, 32'h0000_003F);
    regWrite(8'h43, 32'h1234_5678);
    regRead(8'h43, v); check("R7 slot address rw", v, 32'h1234_5678);
    regRead(8'h20, v); check("R1 unmapped reads zero", v, 32'h0);

    // directed priority and service sequence
    doReset();
    regWrite(8'h42, 32'h0000_A200); regWrite(8'h82, 32'h20 | 9);
    regWrite(8'h47, 32'h0000_A700); regWrite(8'h87, 32'h20 | 4);
    regWrite(8'h4A, 32'h0000_AA00); regWrite(8'h8A, 32'h20 | 12);
    regWrite(A_DEF, 32'h0000_DEF0);
    regWrite(A_ENS, (1 << 4) | (1 << 9) | (1 << 12) | (1 << 20) | (1 << 30));
    setReq(1 << 4);
    check("R6 irqOut high", {31'b0, irqOut}, 32'h1);
    regRead(A_CUR, v); check("R8 slot 7 vector", v, 32'h0000_A700);
    setReq((1 << 4) | (1 << 12) | (1 << 20));
    regRead(A_CUR, v); check("R9 lower priority held off", v, 32'h0000_A700);
    setReq((1 << 4) | (1 << 9) | (1 << 12) | (1 << 20));
    regRead(A_CUR, v); check("R9 higher priority overrides", v, 32'h0000_A200);
    setReq((1 << 4) | (1 << 12) | (1 << 20));
    regRead(A_CUR, v); check("R9 served level holds", v, 32'h0000_A200);
    regWrite(A_CUR, 32'h0);
    regAddr = A_CUR; regRdEn = 1'b1;
    #1 check("R10 same cycle still old", regRdData, 32'h0000_A200);
    @(negedge clk);
    #1 check("R10 rearbitrated next cycle", regRdData, 32'h0000_A700);
    regRdEn = 1'b0;
    regWrite(A_CUR, 32'h0);

    // R8 disabled slot falls back to default; two slots on one source
    regWrite(8'h87, 32'h0000_0004);
    setReq(1 << 4);
    regRead(A_CUR, v); check("R8 disabled slot uses default", v, 32'h0000_DEF0);
    regWrite(A_CUR, 32'h0);
    regWrite(8'h41, 32'h0000_B100); regWrite(8'h81, 32'h20 | 9);
    regWrite(8'h45, 32'h0000_B500); regWrite(8'h85, 32'h20 | 9);
    setReq((1 << 4) | (1 << 9));
    regRead(A_CUR, v); check("R8 lowest slot wins", v, 32'h0000_B100);
    regWrite(A_CUR, 32'h0);

    // R2 / R6 fast routing
    regWrite(A_SEL, (1 << 9) | (1 << 20));
    setReq((1 << 4) | (1 << 9) | (1 << 20));
    check("R6 fiqOut high", {31'b0, fiqOut}, 32'h1);
    regRead(A_FST, v); check("R2 fast status", v, (1 << 9) | (1 << 20));
    regRead(A_NST, v); check("R2 normal status", v, 32'h0000_0010);
    regRead(A_CUR, v); check("R8 fast never vectors", v, 32'h0000_DEF0);
    regWrite(A_CUR, 32'h0);
    regWrite(A_SEL, 32'hFFFF_FFFF);
    setReq(1 << 4);
    check("R6 irqOut low when all fast", {31'b0, irqOut}, 32'h0);
    regRead(A_CUR, v); check("R8 nothing pending reads 0", v, 32'h0);
    regWrite(A_CUR, 32'h0);

    // R5 forcing
    regWrite(A_SEL, 32'h0);
    setReq(32'h0);
    regWrite(A_FRC, 1 << 30);
    regRead(A_FRC, v); check("R5 force readback", v, 32'h4000_0000);
    regRead(A_NST, v); check("R5 forced source active", v, 32'h4000_0000);
    regWrite(A_FCL, 1 << 30);
    regRead(A_NST, v); check("R5 release", v, 32'h0);

    // random mix, no service held across steps
    doReset();
    for (int it = 0; it < 300; it++) begin
      int op = int'($urandom % 8);
      logic [3:0] s = 4'($urandom);
      case (op)
        0: regWrite(A_SEL, $urandom & $urandom & $urandom);
        1: regWrite(A_ENS, $urandom);
        2: regWrite(A_ENC, $urandom & $urandom);
        3: regWrite(A_FRC, $urandom & $urandom & $urandom);
        4: regWrite(A_FCL, $urandom);
        5: regWrite({4'h8, s}, $urandom & 32'h3F);
        6: regWrite({4'h4, s}, $urandom);
        default: regWrite(A_DEF, $urandom);
      endcase
      setReq($urandom & $urandom);
      check("R6 irqOut random", {31'b0, irqOut}, {31'b0, |expN()});
      check("R6 fiqOut random", {31'b0, fiqOut}, {31'b0, |expF()});
      regRead(A_NST, v); check("R1 normal status random", v, expN());
      regRead(A_FST, v); check("R1 fast status random", v, expF());
      regRead(A_CUR, v); check("R8 vector random", v, expCur());
      regWrite(A_CUR, 32'h0);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule